// File: doc/BRIEF.md
# Protected Configuration Register File

This block is the configuration store of a converter front end. It sits behind a host command decoder, which hands it single-cycle write strobes carrying an 8-bit address and a data byte, and read strobes carrying an address. It keeps the settings that the rest of the chip uses: reference and CRC enables, input range, sequencer mode and channel masks, GPIO direction, drive and level, averaging ratio, clock divider, and a set of diagnostic controls. Each of these settings is held in a register and driven straight out of that register.

Some parts of the block have protection rules. The status byte holds two sticky flags that software clears by writing 1 to them: a power-loss flag and an interface-error flag. The interface reports a bad incoming CRC with a one-cycle pulse. While the error flag is set, the block accepts writes only to the status and general-control addresses. The general-control byte also holds two command bits. One is a software reset, which takes effect at once. The other is an offset-calibrate request, which stays set until the calibration logic returns a done pulse. The three diagnostic registers accept writes only while a key register holds the unlock value.

Top module: `cfg_regfile`

## Requirements
- R1: After reset, the status byte at address 0x00 reads 0x81. Its bit 7 always reads 1, and bits 6 to 2 always read 0.
- R2: Status bit 0 (power-loss) and status bit 1 (interface-error) are each cleared by writing 1 to that bit. Writing 0 to them has no effect, and no host write can set either of them.
- R3: A one-cycle `crc_err_pulse` sets status bit 1. If the pulse arrives in the same cycle as a write that clears the bit, the bit still ends up set.
- R4: While status bit 1 is set, writes to any address other than 0x00 and 0x01 are ignored.
- R5: Writing a byte with bit 0 set to address 0x01 returns every register to its reset value, including the key and the diagnostic registers. It also sets status bit 0. The other bits of that same write are discarded, and bit 0 of address 0x01 always reads 0.
- R6: Writing 1 to bit 1 of address 0x01 raises `cal_req`, and the bit reads back as 1. It stays at 1, even if 0 is written to it, until a `cal_done` pulse clears it.
- R7: After reset, address 0x04 reads 0x04 (so `clk_div` is 4). Every other configuration register reads 0x00, and all configuration outputs are 0.
- R8: Only certain bits can be written at each address. At 0x01 the stored bits are 7, 6, 3 and 2. The writable masks are 0xB3 at 0x02, 0x07 at 0x03, 0x1F at 0x04, 0x13 at 0x10, 0x0F at 0x11 and 0x11 at 0xC0. All eight bits are writable at 0x05, 0x07, 0x09, 0x0B, 0x12, 0xBF, 0xC1 and 0xC2. Bits outside a mask keep their reset value.
- R9: Writes to 0xC0, 0xC1 and 0xC2 take effect only while the key register at 0xBF holds 0x96. Writing any other value to the key locks the diagnostic registers again. The key register reads back the last value written to it.
- R10: Addresses that are not implemented read as 0x00 and ignore writes. Address 0x0D returns `gpi_in` after two synchronizer stages and ignores writes.
- R11: A read strobe produces `rd_valid` and `rd_data` in the next cycle. The data reflects the register state before any write made in the same cycle as the read.
- R12: The outputs are taken from these bits:
  - At 0x01: bit 7 drives `ref_en`, bit 6 drives `crc_en`, bit 3 drives `range_2x` and bit 2 drives `ch_force_analog`.
  - At 0x02: bit 7 drives `fixed_pattern`, bits 5:4 drive `append_sel` and bits 1:0 drive `spi_mode`.
  - At 0x10: bits 1:0 drive `seq_mode` and bit 4 drives `seq_start`.
  - At 0x11: bits 3:0 drive `manual_ch`.
  - At 0xC0: bit 4 drives `vtest_en` and bit 0 drives `bitwalk_en`.
  - `bit_sample` is {0xC2, 0xC1}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read address |
| crc_err_pulse | input | 1 | One-cycle incoming CRC error event |
| cal_done | input | 1 | One-cycle calibration finished event |
| gpi_in | input | 8 | Raw GPIO input levels |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| bor_flag | output | 1 | Power-loss flag (status bit 0) |
| crc_err_flag | output | 1 | Interface-error flag (status bit 1) |
| ref_en | output | 1 | Internal reference enable |
| crc_en | output | 1 | Interface CRC enable |
| range_2x | output | 1 | Double input range |
| ch_force_analog | output | 1 | Force all channels to analog |
| cal_req | output | 1 | Offset calibration request |
| fixed_pattern | output | 1 | Fixed output pattern mode |
| append_sel | output | 2 | Data append selection |
| spi_mode | output | 2 | Serial clock polarity and phase |
| osr_sel | output | 3 | Averaging ratio code |
| clk_div | output | 4 | Sample clock divider |
| osc_low_power | output | 1 | Low-power oscillator select |
| pin_is_gpio | output | 8 | Per-channel GPIO select |
| gpio_is_out | output | 8 | Per-GPIO output direction |
| gpo_push_pull | output | 8 | Per-output push-pull drive |
| gpo_level | output | 8 | Output levels |
| seq_mode | output | 2 | Sequencer mode |
| seq_start | output | 1 | Sequencer start |
| manual_ch | output | 4 | Manual channel index |
| auto_ch_mask | output | 8 | Auto-sequence channel mask |
| diag_unlocked | output | 1 | Diagnostic window open |
| vtest_en | output | 1 | Test-voltage diagnostic enable |
| bitwalk_en | output | 1 | Bit-walk diagnostic enable |
| bit_sample | output | 16 | Diagnostic sample bit pattern |

## Verification
The assertions rely on these properties of the inputs:
- `crc_err_pulse` and `cal_done` are single-cycle events, and they never collide with a software-reset write except where that write is meant to win.
- A write to a locked or key-gated address is the only thing that could change the outputs checked there.

The bench stays within these limits. It drives each strobe for exactly one cycle and spaces the event pulses apart from writes. The one exception is the deliberate same-cycle set-versus-clear case of R3, and in that case no software reset is written.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;
  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 8;
  localparam int NUM_CH   = 8;
  localparam int GPI_SYNC = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  localparam addr_t A_STATUS   = 8'h00;
  localparam addr_t A_GENERAL  = 8'h01;
  localparam addr_t A_DATA     = 8'h02;
  localparam addr_t A_OSR      = 8'h03;
  localparam addr_t A_OPMODE   = 8'h04;
  localparam addr_t A_PIN      = 8'h05;
  localparam addr_t A_GPIO_DIR = 8'h07;
  localparam addr_t A_GPO_DRV  = 8'h09;
  localparam addr_t A_GPO_VAL  = 8'h0B;
  localparam addr_t A_GPI      = 8'h0D;
  localparam addr_t A_SEQ      = 8'h10;
  localparam addr_t A_CHSEL    = 8'h11;
  localparam addr_t A_AUTO     = 8'h12;
  localparam addr_t A_KEY      = 8'hBF;
  localparam addr_t A_DIAG_EN  = 8'hC0;
  localparam addr_t A_BITS_LO  = 8'hC1;
  localparam addr_t A_BITS_HI  = 8'hC2;

  localparam data_t UNLOCK_KEY = 8'h96;
  localparam data_t GEN_MASK   = 8'hCC;

  typedef struct packed {
    addr_t addr;
    data_t mask;
    data_t rst;
    logic  diag;
  } plain_desc_t;

  localparam int NUM_PLAIN = 13;
  localparam int I_DATA = 0, I_OSR = 1, I_OPMODE = 2, I_PIN = 3, I_GPIO_DIR = 4,
                 I_GPO_DRV = 5, I_GPO_VAL = 6, I_SEQ = 7, I_CHSEL = 8, I_AUTO = 9,
                 I_DIAG_EN = 10, I_BITS_LO = 11, I_BITS_HI = 12;

  localparam plain_desc_t PLAIN [NUM_PLAIN] = '{
    '{A_DATA,     8'hB3, 8'h00, 1'b0},
    '{A_OSR,      8'h07, 8'h00, 1'b0},
    '{A_OPMODE,   8'h1F, 8'h04, 1'b0},
    '{A_PIN,      8'hFF, 8'h00, 1'b0},
    '{A_GPIO_DIR, 8'hFF, 8'h00, 1'b0},
    '{A_GPO_DRV,  8'hFF, 8'h00, 1'b0},
    '{A_GPO_VAL,  8'hFF, 8'h00, 1'b0},
    '{A_SEQ,      8'h13, 8'h00, 1'b0},
    '{A_CHSEL,    8'h0F, 8'h00, 1'b0},
    '{A_AUTO,     8'hFF, 8'h00, 1'b0},
    '{A_DIAG_EN,  8'h11, 8'h00, 1'b1},
    '{A_BITS_LO,  8'hFF, 8'h00, 1'b1},
    '{A_BITS_HI,  8'hFF, 8'h00, 1'b1}
  };
endpackage

// File: rtl/cfg_plain_reg.sv
module cfg_plain_reg
  import cfg_regfile_pkg::*;
#(
  parameter addr_t ADDR = '0,
  parameter data_t MASK = '1,
  parameter data_t RST  = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  soft_rst,
  input  logic  wr_ok,
  input  addr_t wr_addr,
  input  data_t wr_data,
  output data_t q
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      q <= RST;
    end else if (wr_ok && wr_addr == ADDR) begin
      q <= (wr_data & MASK) | (RST & ~MASK);
    end
  end
endmodule

// File: rtl/cfg_status_ctl.sv
module cfg_status_ctl
  import cfg_regfile_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  addr_t wr_addr,
  input  data_t wr_data,
  input  logic  crc_err_pulse,
  input  logic  cal_done,
  output logic  soft_rst,
  output logic  bor_q,
  output logic  crc_err_q,
  output logic  cal_q,
  output data_t gen_q,
  output data_t status_byte,
  output data_t general_byte
);
  logic wr_status, wr_general;

  assign wr_status  = wr_en && (wr_addr == A_STATUS);
  assign wr_general = wr_en && (wr_addr == A_GENERAL);
  // Command bit 0 of the general byte: immediate, never stored
  assign soft_rst   = wr_general && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      bor_q     <= 1'b1;
      crc_err_q <= 1'b0;
      cal_q     <= 1'b0;
      gen_q     <= '0;
    end else begin
      if (wr_status && wr_data[0]) bor_q <= 1'b0;
      if (wr_status && wr_data[1]) crc_err_q <= 1'b0;
      // error event beats a same-cycle clear
      if (crc_err_pulse) crc_err_q <= 1'b1;
      if (cal_done) cal_q <= 1'b0;
      if (wr_general) begin
        gen_q <= wr_data & GEN_MASK;
        if (wr_data[1]) cal_q <= 1'b1;
      end
    end
  end

  always_comb begin
    status_byte      = '0;
    status_byte[7]   = 1'b1;
    status_byte[1]   = crc_err_q;
    status_byte[0]   = bor_q;
    general_byte     = gen_q;
    general_byte[1]  = cal_q;
  end
endmodule

// File: rtl/cfg_diag_lock.sv
module cfg_diag_lock
  import cfg_regfile_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  soft_rst,
  input  logic  wr_ok,
  input  addr_t wr_addr,
  input  data_t wr_data,
  output data_t key_q,
  output logic  unlocked
);
  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      key_q    <= '0;
      unlocked <= 1'b0;
    end else if (wr_ok && wr_addr == A_KEY) begin
      key_q    <= wr_data;
      unlocked <= (wr_data == UNLOCK_KEY);
    end
  end
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
  import cfg_regfile_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic                crc_err_pulse,
  input  logic                cal_done,
  input  logic [NUM_CH-1:0]   gpi_in,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                bor_flag,
  output logic                crc_err_flag,
  output logic                ref_en,
  output logic                crc_en,
  output logic                range_2x,
  output logic                ch_force_analog,
  output logic                cal_req,
  output logic                fixed_pattern,
  output logic [1:0]          append_sel,
  output logic [1:0]          spi_mode,
  output logic [2:0]          osr_sel,
  output logic [3:0]          clk_div,
  output logic                osc_low_power,
  output logic [NUM_CH-1:0]   pin_is_gpio,
  output logic [NUM_CH-1:0]   gpio_is_out,
  output logic [NUM_CH-1:0]   gpo_push_pull,
  output logic [NUM_CH-1:0]   gpo_level,
  output logic [1:0]          seq_mode,
  output logic                seq_start,
  output logic [3:0]          manual_ch,
  output logic [NUM_CH-1:0]   auto_ch_mask,
  output logic                diag_unlocked,
  output logic                vtest_en,
  output logic                bitwalk_en,
  output logic [2*DATA_W-1:0] bit_sample
);
  logic  soft_rst, bor_q, crc_err_q, cal_q, unlocked, locked_out, wr_ok;
  data_t gen_q, status_byte, general_byte, key_q, rd_mux;
  data_t plain_q [NUM_PLAIN];
  logic [NUM_CH-1:0] gpi_sync [GPI_SYNC];

  cfg_status_ctl u_status (
    .clk, .rst, .wr_en, .wr_addr, .wr_data, .crc_err_pulse, .cal_done,
    .soft_rst, .bor_q, .crc_err_q, .cal_q, .gen_q, .status_byte, .general_byte
  );

  // Lockout exempts the status and general-control addresses
  assign locked_out = crc_err_q && (wr_addr != A_STATUS) && (wr_addr != A_GENERAL);
  assign wr_ok      = wr_en && !locked_out;

  cfg_diag_lock u_diag (
    .clk, .rst, .soft_rst, .wr_ok, .wr_addr, .wr_data, .key_q, .unlocked
  );

  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
    logic en;
    if (PLAIN[i].diag) begin : g_gated
      assign en = wr_ok && unlocked;
    end else begin : g_open
      assign en = wr_ok;
    end
    cfg_plain_reg #(
      .ADDR(PLAIN[i].addr), .MASK(PLAIN[i].mask), .RST(PLAIN[i].rst)
    ) u_reg (
      .clk, .rst, .soft_rst, .wr_ok(en), .wr_addr, .wr_data, .q(plain_q[i])
    );
  end

  for (genvar s = 0; s < GPI_SYNC; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) gpi_sync[s] <= '0;
      else     gpi_sync[s] <= (s == 0) ? gpi_in : gpi_sync[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (rd_addr)
      A_STATUS:  rd_mux = status_byte;
      A_GENERAL: rd_mux = general_byte;
      A_GPI:     rd_mux = gpi_sync[GPI_SYNC-1];
      A_KEY:     rd_mux = key_q;
      default: begin
        for (int i = 0; i < NUM_PLAIN; i++) begin
          if (rd_addr == PLAIN[i].addr) rd_mux = plain_q[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  assign bor_flag        = bor_q;
  assign crc_err_flag    = crc_err_q;
  assign ref_en          = gen_q[7];
  assign crc_en          = gen_q[6];
  assign range_2x        = gen_q[3];
  assign ch_force_analog = gen_q[2];
  assign cal_req         = cal_q;
  assign fixed_pattern   = plain_q[I_DATA][7];
  assign append_sel      = plain_q[I_DATA][5:4];
  assign spi_mode        = plain_q[I_DATA][1:0];
  assign osr_sel         = plain_q[I_OSR][2:0];
  assign clk_div         = plain_q[I_OPMODE][3:0];
  assign osc_low_power   = plain_q[I_OPMODE][4];
  assign pin_is_gpio     = plain_q[I_PIN][NUM_CH-1:0];
  assign gpio_is_out     = plain_q[I_GPIO_DIR][NUM_CH-1:0];
  assign gpo_push_pull   = plain_q[I_GPO_DRV][NUM_CH-1:0];
  assign gpo_level       = plain_q[I_GPO_VAL][NUM_CH-1:0];
  assign seq_mode        = plain_q[I_SEQ][1:0];
  assign seq_start       = plain_q[I_SEQ][4];
  assign manual_ch       = plain_q[I_CHSEL][3:0];
  assign auto_ch_mask    = plain_q[I_AUTO][NUM_CH-1:0];
  assign diag_unlocked   = unlocked;
  assign vtest_en        = plain_q[I_DIAG_EN][4];
  assign bitwalk_en      = plain_q[I_DIAG_EN][0];
  assign bit_sample      = {plain_q[I_BITS_HI], plain_q[I_BITS_LO]};
endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk
  import cfg_regfile_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              crc_err_pulse,
  input logic              cal_done,
  input logic              bor_flag,
  input logic              crc_err_flag,
  input logic              cal_req,
  input logic [NUM_CH-1:0] pin_is_gpio,
  input logic              diag_unlocked,
  input logic              vtest_en,
  input logic              bitwalk_en
);
  logic soft_wr;
  assign soft_wr = wr_en && wr_addr == A_GENERAL && wr_data[0];

  // R1
  status_msb_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid && $past(rd_addr) == A_STATUS |-> rd_data[7]);

  // R2
  bor_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    bor_flag && !(wr_en && wr_addr == A_STATUS && wr_data[0]) |=> bor_flag);

  // R2
  crc_no_self_set_chk: assert property (@(posedge clk) disable iff (rst)
    !crc_err_flag && !crc_err_pulse |=> !crc_err_flag);

  // R3
  crc_set_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err_pulse && !soft_wr |=> crc_err_flag);

  // R4
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    crc_err_flag && wr_en && wr_addr == A_PIN |=> $stable(pin_is_gpio));

  // R6
  cal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cal_req && !cal_done && !soft_wr |=> cal_req);

  // R9
  diag_locked_chk: assert property (@(posedge clk) disable iff (rst)
    !diag_unlocked && wr_en && wr_addr == A_DIAG_EN |=> $stable(vtest_en) && $stable(bitwalk_en));

  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

bind cfg_regfile cfg_regfile_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
  .crc_err_pulse(crc_err_pulse), .cal_done(cal_done), .bor_flag(bor_flag),
  .crc_err_flag(crc_err_flag), .cal_req(cal_req), .pin_is_gpio(pin_is_gpio),
  .diag_unlocked(diag_unlocked), .vtest_en(vtest_en), .bitwalk_en(bitwalk_en)
);

// File: tb/cfg_regfile_bench.sv
module cfg_regfile_bench;
  import cfg_regfile_pkg::*;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, crc_err_pulse = 1'b0, cal_done = 1'b0;
  addr_t wr_addr = '0, rd_addr = '0;
  data_t wr_data = '0;
  logic [NUM_CH-1:0] gpi_in = '0;
  logic rd_valid, bor_flag, crc_err_flag, ref_en, crc_en, range_2x, ch_force_analog;
  logic cal_req, fixed_pattern, osc_low_power, seq_start, diag_unlocked, vtest_en, bitwalk_en;
  data_t rd_data;
  logic [1:0] append_sel, spi_mode, seq_mode;
  logic [2:0] osr_sel;
  logic [3:0] clk_div, manual_ch;
  logic [NUM_CH-1:0] pin_is_gpio, gpio_is_out, gpo_push_pull, gpo_level, auto_ch_mask;
  logic [2*DATA_W-1:0] bit_sample;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cfg_regfile u_cfg_regfile (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input addr_t a, input data_t d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input addr_t a, output data_t d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic rdchk(input string req, input addr_t a, input data_t exp);
    data_t d;
    rd(a, d);
    chk(req, $sformatf("read %02h", a), d, exp);
  endtask

  task automatic pulse_crc();
    @(negedge clk); crc_err_pulse = 1'b1;
    @(negedge clk); crc_err_pulse = 1'b0;
  endtask

  task automatic t_reset();
    rdchk("R1", A_STATUS, 8'h81);
    rdchk("R7", A_GENERAL, 8'h00);
    rdchk("R7", A_OPMODE, 8'h04);
    rdchk("R7", A_PIN, 8'h00);
    rdchk("R7", A_KEY, 8'h00);
    chk("R7", "clk_div", clk_div, 4);
    chk("R7", "outputs", {ref_en, crc_en, cal_req, seq_mode, pin_is_gpio, diag_unlocked}, 0);
  endtask

  task automatic t_masks();
    wr(A_DATA, 8'hFF);   rdchk("R8", A_DATA, 8'hB3);
    chk("R12", "fixed/append/spi", {fixed_pattern, append_sel, spi_mode}, 5'b1_11_11);
    wr(A_OSR, 8'hFF);    rdchk("R8", A_OSR, 8'h07);
    wr(A_OPMODE, 8'hFF); rdchk("R8", A_OPMODE, 8'h1F);
    wr(A_SEQ, 8'hFF);    rdchk("R8", A_SEQ, 8'h13);
    chk("R12", "seq", {seq_start, seq_mode}, 3'b111);
    wr(A_CHSEL, 8'hFF);  rdchk("R8", A_CHSEL, 8'h0F);
    chk("R12", "manual_ch", manual_ch, 4'hF);
    wr(A_AUTO, 8'h3C);   rdchk("R8", A_AUTO, 8'h3C);
    wr(8'h06, 8'hFF);    rdchk("R10", 8'h06, 8'h00);
    wr(A_GENERAL, 8'hFC); rdchk("R8", A_GENERAL, 8'hCC);
    chk("R12", "general outs", {ref_en, crc_en, range_2x, ch_force_analog}, 4'hF);
    wr(A_GENERAL, 8'h00);
  endtask

  task automatic t_w1c();
    data_t d;
    wr(A_STATUS, 8'h00); rdchk("R2", A_STATUS, 8'h81);
    // read and clearing write in the same cycle: read sees old value
    @(negedge clk);
    rd_en = 1'b1; rd_addr = A_STATUS; wr_en = 1'b1; wr_addr = A_STATUS; wr_data = 8'h01;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; d = rd_data;
    chk("R11", "read before write", d, 8'h81);
    chk("R11", "rd_valid", rd_valid, 1'b1);
    rdchk("R2", A_STATUS, 8'h80);
    wr(A_STATUS, 8'hFF); rdchk("R2", A_STATUS, 8'h80);
  endtask

  task automatic t_crc_lock();
    wr(A_PIN, 8'hAA);
    pulse_crc();
    chk("R3", "crc flag", crc_err_flag, 1'b1);
    rdchk("R3", A_STATUS, 8'h82);
    wr(A_PIN, 8'h55);   rdchk("R4", A_PIN, 8'hAA);
    wr(A_KEY, 8'h96);   rdchk("R4", A_KEY, 8'h00);
    wr(A_GENERAL, 8'h40);
    chk("R4", "exempt general write", crc_en, 1'b1);
    wr(A_STATUS, 8'h02); rdchk("R2", A_STATUS, 8'h80);
    wr(A_PIN, 8'h55);    rdchk("R4", A_PIN, 8'h55);
  endtask

  task automatic t_cal();
    wr(A_GENERAL, 8'h42);
    chk("R6", "cal_req set", cal_req, 1'b1);
    rdchk("R6", A_GENERAL, 8'h42);
    repeat (3) @(negedge clk);
    wr(A_GENERAL, 8'h40);
    chk("R6", "cal_req held", cal_req, 1'b1);
    @(negedge clk); cal_done = 1'b1;
    @(negedge clk); cal_done = 1'b0;
    chk("R6", "cal_req cleared", cal_req, 1'b0);
    rdchk("R6", A_GENERAL, 8'h40);
  endtask

  task automatic t_diag();
    wr(A_DIAG_EN, 8'h11); rdchk("R9", A_DIAG_EN, 8'h00);
    wr(A_KEY, 8'h96);
    chk("R9", "unlocked", diag_unlocked, 1'b1);
    rdchk("R9", A_KEY, 8'h96);
    wr(A_DIAG_EN, 8'hFF); rdchk("R9", A_DIAG_EN, 8'h11);
    chk("R12", "vtest/bitwalk", {vtest_en, bitwalk_en}, 2'b11);
    wr(A_BITS_LO, 8'h34); wr(A_BITS_HI, 8'h12);
    chk("R12", "bit_sample", bit_sample, 16'h1234);
    wr(A_KEY, 8'h5A);
    chk("R9", "relocked", diag_unlocked, 1'b0);
    rdchk("R9", A_KEY, 8'h5A);
    wr(A_DIAG_EN, 8'h00); rdchk("R9", A_DIAG_EN, 8'h11);
  endtask

  task automatic t_gpi();
    @(negedge clk); gpi_in = 8'h5A;
    repeat (3) @(negedge clk);
    rdchk("R10", A_GPI, 8'h5A);
    wr(A_GPI, 8'hFF); rdchk("R10", A_GPI, 8'h5A);
  endtask

  task automatic t_soft_reset();
    wr(A_OPMODE, 8'h1F); wr(A_KEY, 8'h96); wr(A_DIAG_EN, 8'h11);
    pulse_crc();
    wr(A_STATUS, 8'h01); rdchk("R2", A_STATUS, 8'h82);
    wr(A_GENERAL, 8'hC3);
    rdchk("R5", A_STATUS, 8'h81);
    rdchk("R5", A_GENERAL, 8'h00);
    rdchk("R5", A_OPMODE, 8'h04);
    rdchk("R5", A_PIN, 8'h00);
    rdchk("R5", A_KEY, 8'h00);
    rdchk("R5", A_DIAG_EN, 8'h00);
    chk("R5", "outs", {cal_req, diag_unlocked, crc_en}, 3'b000);
  endtask

  task automatic t_set_beats_clear();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = A_STATUS; wr_data = 8'h02; crc_err_pulse = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; crc_err_pulse = 1'b0;
    rdchk("R3", A_STATUS, 8'h83);
    wr(A_STATUS, 8'h03); rdchk("R2", A_STATUS, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_masks();
    t_w1c();
    t_crc_lock();
    t_cal();
    t_diag();
    t_gpi();
    t_soft_reset();
    t_set_beats_clear();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule